// File: doc/BRIEF.md
# Qualified Power Switch Detector

This block watches an active-low front-panel power switch and decides whether a press is genuine before anything acts on it. A high-to-low change of the switch, compared against the last level that was accepted, opens a qualification window. During the window the switch is sampled once on every 1 ms tick for `SAMPLES` ticks. The press is thrown away if any sample finds the switch released, or if any sample finds the switch locked out. The switch is locked out when the lid is closed and no adapter is present.

A press that survives the window does one of two things. If the platform reports that it is off, the block emits a single-cycle power-up request and swallows the press, so the chipset never sees it. Otherwise the block drives the forwarded active-low button line low. A release is not qualified: as soon as the synchronized switch goes high again, the forwarded line returns high and a one-cycle release event is reported. The switch, lid and adapter inputs are asynchronous and pass through a flop synchronizer. The tick and the off indication are already in the clock domain.

Top module: `pwr_switch_qual`

## Requirements
- R1: After reset `btn_no` is 1, and `pwrup_req_o` and `release_o` are 0.
- R2: Qualification starts only on a falling edge of the synchronized switch relative to the accepted level. Ticks with the switch high have no effect. A press that is still held after it qualified does not qualify again, and neither does a press that is never given ticks.
- R3: A press that is low on all `SAMPLES` consecutive ticks qualifies. With the platform on, `btn_no` goes to 0 at the clock edge that takes the last tick.
- R4: If the switch is high at any tick of the window, the press is rejected. Outputs do not change, no release event occurs, and the accepted level stays high.
- R5: The switch is disabled when `lid_ni`=0 (lid closed) and `ac_ni`=1 (adapter absent). A tick that sees this rejects the press. A press still held is retried, and it qualifies after `SAMPLES` further ticks once the lockout clears. The other three lid/adapter combinations do not block a press.
- R6: If `off_i`=1 on the qualifying tick, `pwrup_req_o` pulses high for exactly one cycle and `btn_no` stays 1 for that whole press. A later press with `off_i`=0 is forwarded normally.
- R7: While a window is open, `btn_no` holds its previous value.
- R8: When the synchronized switch rises while the accepted level is low, `btn_no` returns to 1 and `release_o` pulses for one cycle, with no tick needed. This also applies to a swallowed press.
- R9: `sw_ni`, `lid_ni` and `ac_ni` pass through `SYNC_STAGES` flops. A release shows on `release_o` exactly `SYNC_STAGES`+1 clock edges after the switch input changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sw_ni | input | 1 | Front-panel power switch, active low, asynchronous |
| lid_ni | input | 1 | Lid sense, 0 = closed, asynchronous |
| ac_ni | input | 1 | Adapter sense, 1 = absent, asynchronous |
| off_i | input | 1 | Platform is in the fully-off state |
| tick_i | input | 1 | One-cycle pulse every 1 ms |
| pwrup_req_o | output | 1 | One-cycle power-up request |
| btn_no | output | 1 | Forwarded active-low button level |
| release_o | output | 1 | One-cycle release event |

## Verification
The hardest case to reach is a lockout that arrives partway through a press that is still held. The window is rejected while the switch stays low, so the detector retries at once on every cycle and keeps rejecting while the lockout lasts. Reaching this needs a press that is held, some ticks, then a change of lid and adapter through the synchronizer before the next tick, then more ticks while still locked out, and then the lid opening again. The stimulus walks that path and counts the full window that must follow. It also sweeps the tick on which a bounce lands across every position of the window, and covers all four lid/adapter combinations.

// File: rtl/pwr_switch_pkg.sv
`timescale 1ns/1ps
package pwr_switch_pkg;
  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_QUAL = 1'b1
  } qual_state_e;

  // sync vector lanes
  localparam int LANE_SW  = 0;
  localparam int LANE_LID = 1;
  localparam int LANE_AC  = 2;
  localparam int LANES    = 3;
endpackage

// File: rtl/pws_sync.sv
`timescale 1ns/1ps
module pws_sync #(
  parameter int          WIDTH   = 3,
  parameter int          STAGES  = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] stg_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) stg_q[s] <= RST_VAL;
        else         stg_q[s] <= d_i;
    end else begin : g_next
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) stg_q[s] <= RST_VAL;
        else         stg_q[s] <= stg_q[s-1];
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/pws_qual_fsm.sv
`timescale 1ns/1ps
module pws_qual_fsm
  import pwr_switch_pkg::*;
#(
  parameter int SAMPLES = 100
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sw_i,      // synchronized, active low
  input  logic lock_i,    // press lockout
  input  logic off_i,
  input  logic tick_i,
  output logic pwrup_req_o,
  output logic btn_no,
  output logic release_o
);
  localparam int CW = (SAMPLES > 1) ? $clog2(SAMPLES) : 1;
  localparam logic [CW-1:0] LAST = CW'(SAMPLES - 1);

  qual_state_e st_q, st_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic level_q, level_d;     // accepted switch level
  logic swallow_q, swallow_d; // press consumed by power-up
  logic btn_q, req_q, rel_q;
  logic req_d, rel_d;

  always_comb begin
    st_d      = st_q;
    cnt_d     = cnt_q;
    level_d   = level_q;
    swallow_d = swallow_q;
    req_d     = 1'b0;
    rel_d     = 1'b0;
    unique case (st_q)
      ST_IDLE: begin
        if (!sw_i && level_q) begin
          st_d  = ST_QUAL;
          cnt_d = '0;
        end else if (sw_i && !level_q) begin
          level_d   = 1'b1;
          swallow_d = 1'b0;
          rel_d     = 1'b1;
        end
      end
      ST_QUAL: begin
        if (tick_i) begin
          if (sw_i || lock_i) begin
            st_d = ST_IDLE;            // reject, level untouched
          end else if (cnt_q == LAST) begin
            st_d    = ST_IDLE;
            level_d = 1'b0;
            if (off_i) begin
              swallow_d = 1'b1;
              req_d     = 1'b1;
            end
          end else begin
            cnt_d = cnt_q + 1'b1;
          end
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q      <= ST_IDLE;
      cnt_q     <= '0;
      level_q   <= 1'b1;
      swallow_q <= 1'b0;
      btn_q     <= 1'b1;
      req_q     <= 1'b0;
      rel_q     <= 1'b0;
    end else begin
      st_q      <= st_d;
      cnt_q     <= cnt_d;
      level_q   <= level_d;
      swallow_q <= swallow_d;
      btn_q     <= level_d | swallow_d;
      req_q     <= req_d;
      rel_q     <= rel_d;
    end
  end

  assign pwrup_req_o = req_q;
  assign btn_no      = btn_q;
  assign release_o   = rel_q;

  assert_req_needs_off_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_q |-> ($past(off_i) && $past(tick_i)));
  assert_req_single_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_q |=> !req_q);
  assert_btn_fall_on_tick_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(btn_q) |-> ($past(tick_i) && !$past(off_i) && !$past(sw_i) && !$past(lock_i)));
  assert_release_on_high_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rel_q |-> ($past(sw_i) && btn_q));
  assert_cnt_bound_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_QUAL) |-> (cnt_q <= LAST));
  assert_hold_in_window_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(st_q) == ST_QUAL && st_q == ST_QUAL) |-> $stable(btn_q));
endmodule

// File: rtl/pwr_switch_qual.sv
`timescale 1ns/1ps
module pwr_switch_qual
  import pwr_switch_pkg::*;
#(
  parameter int SAMPLES     = 100,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sw_ni,
  input  logic lid_ni,
  input  logic ac_ni,
  input  logic off_i,
  input  logic tick_i,
  output logic pwrup_req_o,
  output logic btn_no,
  output logic release_o
);
  // reset: switch released, lid open, adapter present
  localparam logic [LANES-1:0] SYNC_RST = LANES'(3'b011);

  logic [LANES-1:0] raw, syn;
  logic lock;

  assign raw[LANE_SW]  = sw_ni;
  assign raw[LANE_LID] = lid_ni;
  assign raw[LANE_AC]  = ac_ni;

  pws_sync #(
    .WIDTH  (LANES),
    .STAGES (SYNC_STAGES),
    .RST_VAL(SYNC_RST)
  ) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (raw),
    .q_o   (syn)
  );

  // lid closed on battery
  assign lock = !syn[LANE_LID] && syn[LANE_AC];

  pws_qual_fsm #(
    .SAMPLES(SAMPLES)
  ) u_fsm (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .sw_i       (syn[LANE_SW]),
    .lock_i     (lock),
    .off_i      (off_i),
    .tick_i     (tick_i),
    .pwrup_req_o(pwrup_req_o),
    .btn_no     (btn_no),
    .release_o  (release_o)
  );

  assert_pulses_excl_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(pwrup_req_o && release_o));
endmodule

// File: tb/pwr_switch_qual_bench.sv
`timescale 1ns/1ps
module pwr_switch_qual_bench;
  localparam int S  = 6;
  localparam int SY = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sw_n = 1'b1, lid_n = 1'b1, ac_n = 1'b0, off = 1'b0, tick = 1'b0;
  logic req, btn_n, rel;

  int n_tests = 0, n_fail = 0, n_req = 0, n_rel = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  pwr_switch_qual #(.SAMPLES(S), .SYNC_STAGES(SY)) u_pwr_switch_qual (
    .clk_i(clk), .rst_ni(rst_n), .sw_ni(sw_n), .lid_ni(lid_n), .ac_ni(ac_n),
    .off_i(off), .tick_i(tick), .pwrup_req_o(req), .btn_no(btn_n), .release_o(rel)
  );

  always @(negedge clk) if (rst_n) begin
    if (req) n_req++;
    if (rel) n_rel++;
  end

  task automatic check(input string r, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", r, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic settle();
    cyc(SY + 3);
  endtask

  task automatic tk();
    @(negedge clk) tick = 1'b1;
    @(negedge clk) tick = 1'b0;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) tk();
  endtask

  task automatic press();
    @(negedge clk) sw_n = 1'b0;
    settle();
  endtask

  task automatic release_sw();
    @(negedge clk) sw_n = 1'b1;
    settle();
    tk(); // flush any open window
  endtask

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: actual 0 expected 1");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    int r0, q0;
    cyc(3);
    rst_n = 1'b1;
    cyc(1);
    // R1
    check("R1 btn", btn_n, 1);
    check("R1 req", req, 0);
    check("R1 rel", rel, 0);

    // R2 idle ticks
    ticks(10);
    check("R2 idle btn", btn_n, 1);
    check("R2 idle pulses", n_req + n_rel, 0);

    // R3 / R7 forwarded press
    press();
    for (int i = 0; i < S - 1; i++) begin
      tk();
      check("R7 hold in window", btn_n, 1);
    end
    tk();
    check("R3 qualified", btn_n, 0);
    ticks(3);
    check("R2 held no requal btn", btn_n, 0);
    check("R2 held no req", n_req, 0);

    // R8 / R9 release latency
    r0 = n_rel;
    @(negedge clk) sw_n = 1'b1;
    for (int k = 1; k <= SY + 2; k++) begin
      @(negedge clk);
      check("R9 release latency", rel, (k == SY + 1) ? 1 : 0);
    end
    check("R8 btn after release", btn_n, 1);
    check("R8 one release", n_rel - r0, 1);

    // R4 bounce at every window position
    for (int b = 0; b < S; b++) begin
      r0 = n_rel;
      press();
      ticks(b);
      @(negedge clk) sw_n = 1'b1;
      settle();
      tk();
      cyc(2);
      check("R4 bounce btn", btn_n, 1);
      check("R4 bounce no release", n_rel - r0, 0);
      check("R4 bounce no req", n_req, 0);
    end
    press();
    ticks(S);
    check("R4 press after bounce", btn_n, 0);
    release_sw();

    // R5 lid/adapter combinations
    for (int c = 0; c < 4; c++) begin
      @(negedge clk) begin lid_n = c[0]; ac_n = c[1]; end
      settle();
      press();
      ticks(S + 2);
      check("R5 lockout combo", btn_n, (c == 2) ? 1 : 0);
      release_sw();
      check("R5 combo released", btn_n, 1);
    end
    @(negedge clk) begin lid_n = 1'b1; ac_n = 1'b0; end
    settle();

    // R5 lockout mid-window, then retry
    press();
    ticks(2);
    @(negedge clk) begin lid_n = 1'b0; ac_n = 1'b1; end
    settle();
    tk();
    check("R5 mid-window reject", btn_n, 1);
    ticks(3);
    check("R5 retries rejected", btn_n, 1);
    @(negedge clk) lid_n = 1'b1;
    settle();
    ticks(S - 1);
    check("R5 retry window open", btn_n, 1);
    tk();
    check("R5 retry qualified", btn_n, 0);
    release_sw();
    @(negedge clk) ac_n = 1'b0;
    settle();

    // R6 power-up from off
    @(negedge clk) off = 1'b1;
    q0 = n_req;
    r0 = n_rel;
    press();
    ticks(S - 1);
    check("R6 no early req", n_req - q0, 0);
    tk();
    check("R6 req pulse", req, 1);
    check("R6 swallowed", btn_n, 1);
    cyc(1);
    check("R6 req one cycle", req, 0);
    ticks(S + 2);
    check("R6 single req", n_req - q0, 1);
    check("R6 still swallowed", btn_n, 1);
    @(negedge clk) off = 1'b0;
    release_sw();
    check("R8 swallowed release event", n_rel - r0, 1);
    check("R6 btn after swallow", btn_n, 1);
    press();
    ticks(S);
    check("R6 next press forwarded", btn_n, 0);
    release_sw();

    // R2 press with no ticks never qualifies
    press();
    cyc(50);
    check("R2 no ticks btn", btn_n, 1);
    check("R2 no ticks req", req, 0);
    release_sw();

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule